// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the register updates a processor core needs when it takes an exception. A requester presents a 3-bit exception code together with the current 32-bit status word and the current program counter. On the next clock edge the controller registers six results. These are the target mode for the banked register file, the status word to save into that mode's saved-status slot, the return address for the mode's link register, the rewritten status word, and the handler's program counter. A one-cycle completion pulse marks them as fresh.

Each code has a fixed handler address and a fixed target mode. The status rewrite keeps the upper bits and forces the 32-bit instruction state. It always masks normal interrupts, and it masks fast interrupts only for the reset and fast-interrupt codes. Synchronous reset leaves the outputs exactly as if the reset exception had just been taken. The block does not arbitrate between simultaneous exceptions and does not handle the return path.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs become `done`=0, `pc_out`=0x0000_0000, `mode_out`=5'b10011, `status_out`=0x0000_00D3, `saved_status`=0 and `link_addr`=0.
- R2: A request (`req_valid`=1) sampled at an edge while `done` is low is accepted. `done` is high in the following cycle only, and all data outputs carry that request's results in that cycle.
- R3: A request presented while `done` is high is ignored. `done` is low in the next cycle and no data output changes.
- R4: `pc_out` equals VEC_BASE + 4 × code. The codes are 0 reset, 1 undefined instruction, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 reserved, 6 interrupt, 7 fast interrupt.
- R5: `mode_out` is 10011 (supervisor) for codes 0, 2 and 5. It is 10111 (abort) for codes 3 and 4, 11011 (undefined) for code 1, 10010 (interrupt) for code 6 and 10001 (fast interrupt) for code 7.
- R6: `saved_status` equals the `cur_status` presented with the accepted request.
- R7: `link_addr` equals the `cur_pc` presented with the accepted request.
- R8: In `status_out`, bits 4:0 hold the target mode, bit 5 (instruction state) is 0 and bit 7 (interrupt mask) is 1. Bits 31:8 equal the accepted `cur_status` bits 31:8.
- R9: `status_out` bit 6 (fast-interrupt mask) is 1 for codes 0 and 7 and 0 for every other code.
- R10: With no accepted request, every data output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request |
| req_code | input | 3 | Exception code |
| cur_status | input | 32 | Status word before entry |
| cur_pc | input | 32 | Program counter before entry |
| done | output | 1 | One-cycle completion pulse |
| mode_out | output | 5 | Target mode for the banked register file |
| saved_status | output | 32 | Value for the target mode's saved-status slot |
| link_addr | output | 32 | Return address for the target mode's link register |
| status_out | output | 32 | Rewritten status word |
| pc_out | output | 32 | Handler address |

## Verification
The assertions check several properties on every completion cycle. They confirm that `done` is a single-cycle pulse, that the saved status and link address match the inputs sampled one edge earlier, and that the interrupt mask is set. They also check that the state bit is clear, that the mode field agrees with `mode_out`, and that the fast-interrupt mask agrees with the mode and vector. Only the bench's scenarios can show the exact vector and mode chosen for each of the eight codes, that a request during the pulse is dropped, that outputs hold while idle, and the value loaded by reset.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    EXC_RESET = 3'd0,
    EXC_UNDEF = 3'd1,
    EXC_SWI   = 3'd2,
    EXC_PABT  = 3'd3,
    EXC_DABT  = 3'd4,
    EXC_RSVD  = 3'd5,
    EXC_IRQ   = 3'd6,
    EXC_FIQ   = 3'd7
  } exc_code_e;

  localparam int MODE_W = 5;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

  localparam int ST_T_BIT = 5;
  localparam int ST_F_BIT = 6;
  localparam int ST_I_BIT = 7;
  localparam int ST_KEEP_LSB = 8;

endpackage

// File: rtl/exc_vector_map.sv
module exc_vector_map
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic [2:0]        code,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [MODE_W-1:0] tgt_mode,
  output logic              fiq_mask
);
  localparam int SLOT_SHIFT = 2;

  exc_code_e kind;

  always_comb begin
    kind     = exc_code_e'(code);
    vec_addr = VEC_BASE + (ADDR_W'(code) << SLOT_SHIFT);
    fiq_mask = 1'b0;
    unique case (kind)
      EXC_RESET: begin tgt_mode = MODE_SVC; fiq_mask = 1'b1; end
      EXC_UNDEF: tgt_mode = MODE_UND;
      EXC_SWI:   tgt_mode = MODE_SVC;
      EXC_PABT:  tgt_mode = MODE_ABT;
      EXC_DABT:  tgt_mode = MODE_ABT;
      EXC_RSVD:  tgt_mode = MODE_SVC;
      EXC_IRQ:   tgt_mode = MODE_IRQ;
      EXC_FIQ:   begin tgt_mode = MODE_FIQ; fiq_mask = 1'b1; end
      default:   tgt_mode = MODE_SVC;
    endcase
  end
endmodule

// File: rtl/exc_status_gen.sv
module exc_status_gen
  import exc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_status,
  input  logic [MODE_W-1:0] tgt_mode,
  input  logic              fiq_mask,
  output logic [DATA_W-1:0] new_status
);
  localparam int KEEP_W = DATA_W - ST_KEEP_LSB;

  always_comb begin
    new_status = {old_status[DATA_W-1:ST_KEEP_LSB], {ST_KEEP_LSB{1'b0}}};
    new_status[MODE_W-1:0] = tgt_mode;
    new_status[ST_T_BIT]   = 1'b0;
    new_status[ST_F_BIT]   = fiq_mask;
    new_status[ST_I_BIT]   = 1'b1;
  end

  initial begin
    if (KEEP_W < 1) $error("DATA_W too small for status layout");
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 3,
  parameter logic [DATA_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic [DATA_W-1:0] cur_status,
  input  logic [DATA_W-1:0] cur_pc,
  output logic              done,
  output logic [MODE_W-1:0] mode_out,
  output logic [DATA_W-1:0] saved_status,
  output logic [DATA_W-1:0] link_addr,
  output logic [DATA_W-1:0] status_out,
  output logic [DATA_W-1:0] pc_out
);
  localparam logic [DATA_W-1:0] RESET_STATUS =
    DATA_W'({1'b1, 1'b1, 1'b0, MODE_SVC});

  logic [DATA_W-1:0] vec_addr;
  logic [MODE_W-1:0] tgt_mode;
  logic              fiq_mask;
  logic [DATA_W-1:0] next_status;
  logic              accept;

  exc_vector_map #(.ADDR_W(DATA_W), .VEC_BASE(VEC_BASE)) u_map (
    .code     (req_code[2:0]),
    .vec_addr (vec_addr),
    .tgt_mode (tgt_mode),
    .fiq_mask (fiq_mask)
  );

  exc_status_gen #(.DATA_W(DATA_W)) u_stat (
    .old_status (cur_status),
    .tgt_mode   (tgt_mode),
    .fiq_mask   (fiq_mask),
    .new_status (next_status)
  );

  assign accept = req_valid && !done;

  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b0;
      mode_out     <= MODE_SVC;
      saved_status <= '0;
      link_addr    <= '0;
      status_out   <= RESET_STATUS;
      pc_out       <= VEC_BASE;
    end else begin
      done <= accept;
      if (accept) begin
        mode_out     <= tgt_mode;
        saved_status <= cur_status;
        link_addr    <= cur_pc;
        status_out   <= next_status;
        pc_out       <= vec_addr;
      end
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_drop_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (done && req_valid) |=> $stable(pc_out) && $stable(status_out));

  assert_pc_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (pc_out[1:0] == 2'b00));

  assert_mode_field_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (status_out[MODE_W-1:0] == mode_out));

  assert_saved_copy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (saved_status == $past(cur_status)));

  assert_link_copy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (link_addr == $past(cur_pc)));

  assert_status_bits_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (status_out[ST_I_BIT] && !status_out[ST_T_BIT]
              && status_out[DATA_W-1:ST_KEEP_LSB] == saved_status[DATA_W-1:ST_KEEP_LSB]));

  assert_fiq_mask_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (status_out[ST_F_BIT] == ((mode_out == MODE_FIQ) || (pc_out == VEC_BASE))));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !$past(rst)) |=> $stable(pc_out) && $stable(link_addr));
endmodule

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  req_code;
  logic [31:0] cur_status;
  logic [31:0] cur_pc;
  logic        done;
  logic [4:0]  mode_out;
  logic [31:0] saved_status;
  logic [31:0] link_addr;
  logic [31:0] status_out;
  logic [31:0] pc_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
    .cur_status(cur_status), .cur_pc(cur_pc), .done(done),
    .mode_out(mode_out), .saved_status(saved_status), .link_addr(link_addr),
    .status_out(status_out), .pc_out(pc_out)
  );

  // fields: [104:102] code, [101:70] status in, [69:38] pc in,
  //         [37:6] expected vector, [5:1] expected mode, [0] expected fast mask
  localparam logic [104:0] VECS [8] = '{
    {3'd0, 32'h6000_0010, 32'h0000_1234, 32'h0000_0000, 5'b10011, 1'b1},
    {3'd1, 32'h8000_0030, 32'h0000_0100, 32'h0000_0004, 5'b11011, 1'b0},
    {3'd2, 32'h2000_0050, 32'h0000_2000, 32'h0000_0008, 5'b10011, 1'b0},
    {3'd3, 32'h1000_0011, 32'h0000_3004, 32'h0000_000C, 5'b10111, 1'b0},
    {3'd4, 32'hF123_451F, 32'h8000_0008, 32'h0000_0010, 5'b10111, 1'b0},
    {3'd5, 32'h0000_0013, 32'h0000_0044, 32'h0000_0014, 5'b10011, 1'b0},
    {3'd6, 32'h4000_0030, 32'h0800_0100, 32'h0000_0018, 5'b10010, 1'b0},
    {3'd7, 32'hC000_0010, 32'h0800_0200, 32'h0000_001C, 5'b10001, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(input logic [31:0] st, input logic [4:0] m,
                                             input logic f);
    return {st[31:8], 1'b1, f, 1'b0, m};
  endfunction

  // drive at negedge, accepted at next posedge, checked at following negedge
  task automatic issue(input logic [2:0] c, input logic [31:0] st, input logic [31:0] pc);
    req_valid  = 1'b1;
    req_code   = c;
    cur_status = st;
    cur_pc     = pc;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    rst = 1'b1; req_valid = 1'b0; req_code = '0; cur_status = '0; cur_pc = '0;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 pc", pc_out, 32'h0);
    chk("R1 mode", 32'(mode_out), 32'h13);
    chk("R1 status", status_out, 32'h0000_00D3);
    chk("R1 link", link_addr, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // table walk: R2 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 8; i++) begin
      logic [104:0] v;
      v = VECS[i];
      issue(v[104:102], v[101:70], v[69:38]);
      chk("R2 done", 32'(done), 32'd1);
      chk("R4 vector", pc_out, v[37:6]);
      chk("R5 mode", 32'(mode_out), 32'(v[5:1]));
      chk("R6 saved", saved_status, v[101:70]);
      chk("R7 link", link_addr, v[69:38]);
      chk("R8 R9 status", status_out, exp_status(v[101:70], v[5:1], v[0]));
      @(negedge clk);
      chk("R2 pulse ends", 32'(done), 32'd0);
    end

    // R3: request during done is dropped
    issue(3'd6, 32'h5000_0010, 32'h0000_0A00);
    chk("R3 first done", 32'(done), 32'd1);
    req_valid = 1'b1; req_code = 3'd7; cur_status = 32'hAAAA_AA10; cur_pc = 32'h0000_0B00;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 no done", 32'(done), 32'd0);
    chk("R3 pc kept", pc_out, 32'h0000_0018);
    chk("R3 link kept", link_addr, 32'h0000_0A00);
    chk("R3 mode kept", 32'(mode_out), 32'h12);

    // R10: idle with changing inputs
    cur_status = 32'h1234_5678; cur_pc = 32'h8765_4321; req_code = 3'd1;
    repeat (3) @(negedge clk);
    chk("R10 pc hold", pc_out, 32'h0000_0018);
    chk("R10 saved hold", saved_status, 32'h5000_0010);
    chk("R10 status hold", status_out, 32'h5000_0092);

    // R1 again: mid-run reset overrides a pending request
    rst = 1'b1; req_valid = 1'b1; req_code = 3'd4;
    @(negedge clk);
    rst = 1'b0; req_valid = 1'b0;
    chk("R1 rerun status", status_out, 32'h0000_00D3);
    chk("R1 rerun pc", pc_out, 32'h0);
    chk("R1 rerun saved", saved_status, 32'h0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule